// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block carries out the state bookkeeping of a small processor core when it enters an exception handler and when it returns from one. A requester presents an exception type code, a critical flag, the address to resume at, the data address that failed and syndrome bits. It holds `req_valid` until `ack`. The sequencer then does four things in one clock edge:
- it saves the resume address and the current machine state into one of two save pairs;
- it updates the syndrome and fault-address registers for the types that report them;
- it loads a privileged, untranslated machine state;
- it registers the handler fetch address.

On the following cycle it presents that fetch address. Two return operations, normal and critical, reload the machine state and the resume address from the matching save pair. A return issued outside privileged mode is refused with a program-exception request.

The sequencer has four states:
- **IDLE** waits for work.
- **VECTOR** presents the handler address.
- **RESUME** presents the address restored by a return.
- **REJECT** raises the program-exception request.

Its transitions are:
- IDLE→VECTOR when an exception is accepted.
- IDLE→RESUME when a privileged return is accepted.
- IDLE→REJECT when an unprivileged return arrives.
- VECTOR, RESUME and REJECT each return to IDLE unconditionally after one cycle.

Machine-state bit layout (`msr`): [4] critical enable, [3] noncritical enable, [2] privileged, [1] instruction translation, [0] data translation. The reset value is 5'b00100.

Top module: `trap_seq`

## Requirements
- R1: A critical exception entry copies `msr` into `srr3` and `req_pc` into `srr2`, and leaves `srr0`/`srr1` unchanged.
- R2: A noncritical exception entry copies `msr` into `srr1` and `req_pc` into `srr0`, and leaves `srr2`/`srr3` unchanged.
- R3: `esr` takes `req_syn` only for type codes 1, 2, 3, 6 and 11. For every other code it keeps its value.
- R4: `dear` takes `req_daddr` only for type codes 2, 5 and 11. For every other code it keeps its value.
- R5: Every entry sets `msr[2]` (privileged) and clears `msr[1]` and `msr[0]` (translation off).
- R6: A critical entry clears `msr[4]` and `msr[3]`. A noncritical entry clears `msr[3]` and keeps `msr[4]`.
- R7: The handler address is the upper 16 bits of the prefix register followed by the 16-bit offset (type+1)×0x100, so type 15 gives 0x1000. A prefix write discards bits [15:0] of `pfx_wdata`.
- R8: Entry is context synchronizing. `ack` and `fetch_valid` are never high in the cycle an exception is accepted. Both are high for exactly the one cycle that follows, and the new `msr` is already visible in that cycle.
- R9: A normal return (`ret_crit`=0) loads `msr` from `srr1` and fetches from `srr0`. A critical return (`ret_crit`=1) uses `srr3`/`srr2`. `fetch_valid` and `ack` are high in the cycle after acceptance.
- R10: A return issued while `msr[2]`=0 restores nothing. It raises `prog_req` and `ack` for one cycle, keeps `fetch_valid` low and leaves `msr` unchanged.
- R11: When an exception request and a return arrive together, the exception is taken. A machine-state write (`msr_we`) takes effect only in IDLE with neither request present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception request, held until `ack` |
| req_type | input | 4 | Exception type code |
| req_crit | input | 1 | 1 = critical class |
| req_pc | input | 32 | Resume address to save |
| req_daddr | input | 32 | Failed data address |
| req_syn | input | 8 | Syndrome bits |
| ret_valid | input | 1 | Return request, held until `ack` |
| ret_crit | input | 1 | 1 = critical return |
| msr_we | input | 1 | Machine-state write strobe |
| msr_wdata | input | 5 | Machine-state write value |
| pfx_we | input | 1 | Vector prefix write strobe |
| pfx_wdata | input | 32 | Vector prefix write value |
| ack | output | 1 | Request taken (one cycle) |
| fetch_valid | output | 1 | `fetch_addr` is valid |
| fetch_addr | output | 32 | Handler or resume fetch address |
| prog_req | output | 1 | Program exception for an unprivileged return |
| msr | output | 5 | Current machine state |
| srr0 | output | 32 | Noncritical saved address |
| srr1 | output | 5 | Noncritical saved state |
| srr2 | output | 32 | Critical saved address |
| srr3 | output | 5 | Critical saved state |
| esr | output | 8 | Syndrome register |
| dear | output | 32 | Fault data-address register |

## Verification
Requests are taken at the rising edge where the sequencer sits in IDLE. Every saved register, `esr`, `dear` and `msr` has its new value right after that edge. `ack`, `fetch_valid`, `fetch_addr` and `prog_req` are high only during the single following cycle, and they drop after the next edge. The bench drives each request at a falling edge, withdraws it at the next falling edge, and samples every result at that same falling edge, which is one register stage after acceptance. It then samples again one cycle later to confirm that the strobes have dropped.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef struct packed {
        logic ce;    // critical interrupts enabled
        logic ee;    // noncritical interrupts enabled
        logic priv;  // privileged mode
        logic ir;    // instruction translation on
        logic dr;    // data translation on
    } msr_t;

    localparam int MSR_W = $bits(msr_t);
    localparam logic [MSR_W-1:0] MSR_RESET = 5'b00100;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_VECTOR,
        ST_RESUME,
        ST_REJECT
    } state_e;

    localparam logic [3:0] EXC_MCHK  = 4'd1;
    localparam logic [3:0] EXC_DSTOR = 4'd2;
    localparam logic [3:0] EXC_ISTOR = 4'd3;
    localparam logic [3:0] EXC_ALIGN = 4'd5;
    localparam logic [3:0] EXC_PROG  = 4'd6;
    localparam logic [3:0] EXC_DTLB  = 4'd11;

endpackage

// File: rtl/trap_class.sv
module trap_class
    import trap_pkg::*;
#(
    parameter int TYPE_W = 4
) (
    input  logic [TYPE_W-1:0] exc_type,
    output logic              syn_hit,
    output logic              addr_hit
);
    logic [3:0] code;

    assign code = 4'(exc_type);

    always_comb begin
        unique case (code)
            EXC_MCHK, EXC_ISTOR, EXC_PROG: begin
                syn_hit  = 1'b1;
                addr_hit = 1'b0;
            end
            EXC_DSTOR, EXC_DTLB: begin
                syn_hit  = 1'b1;
                addr_hit = 1'b1;
            end
            EXC_ALIGN: begin
                syn_hit  = 1'b0;
                addr_hit = 1'b1;
            end
            default: begin
                syn_hit  = 1'b0;
                addr_hit = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/trap_vec.sv
module trap_vec #(
    parameter int AW      = 32,
    parameter int ALIGN_W = 16,
    parameter int TYPE_W  = 4,
    parameter int OFF_SH  = 8
) (
    input  logic [AW-ALIGN_W-1:0] base_hi,
    input  logic [TYPE_W-1:0]     exc_type,
    output logic [AW-1:0]         vec_addr
);
    localparam int NTYPES = 1 << TYPE_W;

    logic [ALIGN_W-1:0] off_tbl [NTYPES];

    for (genvar g = 0; g < NTYPES; g++) begin : g_off
        assign off_tbl[g] = ALIGN_W'((g + 1) << OFF_SH);
    end

    assign vec_addr = {base_hi, off_tbl[exc_type]};
endmodule

// File: rtl/trap_seq.sv
module trap_seq
    import trap_pkg::*;
#(
    parameter int AW      = 32,
    parameter int SYN_W   = 8,
    parameter int TYPE_W  = 4,
    parameter int ALIGN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [TYPE_W-1:0] req_type,
    input  logic              req_crit,
    input  logic [AW-1:0]     req_pc,
    input  logic [AW-1:0]     req_daddr,
    input  logic [SYN_W-1:0]  req_syn,
    input  logic              ret_valid,
    input  logic              ret_crit,
    input  logic              msr_we,
    input  logic [MSR_W-1:0]  msr_wdata,
    input  logic              pfx_we,
    input  logic [AW-1:0]     pfx_wdata,
    output logic              ack,
    output logic              fetch_valid,
    output logic [AW-1:0]     fetch_addr,
    output logic              prog_req,
    output logic [MSR_W-1:0]  msr,
    output logic [AW-1:0]     srr0,
    output logic [MSR_W-1:0]  srr1,
    output logic [AW-1:0]     srr2,
    output logic [MSR_W-1:0]  srr3,
    output logic [SYN_W-1:0]  esr,
    output logic [AW-1:0]     dear
);
    localparam int HI_W = AW - ALIGN_W;

    state_e             state_q, state_d;
    msr_t               msr_q, srr1_q, srr3_q;
    logic [AW-1:0]      srr0_q, srr2_q, dear_q, tgt_q, vec_addr;
    logic [SYN_W-1:0]   esr_q;
    logic [HI_W-1:0]    pfx_hi_q;
    logic               syn_upd, addr_upd;
    logic               take_exc, take_ret, ret_ok;
    wire                unused_pfx_lo = ^pfx_wdata[ALIGN_W-1:0];

    trap_class #(.TYPE_W(TYPE_W)) u_class (
        .exc_type (req_type),
        .syn_hit  (syn_upd),
        .addr_hit (addr_upd)
    );

    trap_vec #(.AW(AW), .ALIGN_W(ALIGN_W), .TYPE_W(TYPE_W)) u_vec (
        .base_hi  (pfx_hi_q),
        .exc_type (req_type),
        .vec_addr (vec_addr)
    );

    assign take_exc = (state_q == ST_IDLE) && req_valid;
    assign take_ret = (state_q == ST_IDLE) && !req_valid && ret_valid;
    assign ret_ok   = take_ret && msr_q.priv;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_exc)     state_d = ST_VECTOR;
                else if (ret_ok)  state_d = ST_RESUME;
                else if (take_ret) state_d = ST_REJECT;
            end
            ST_VECTOR: state_d = ST_IDLE;
            ST_RESUME: state_d = ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ack         = 1'b0;
        fetch_valid = 1'b0;
        prog_req    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_VECTOR, ST_RESUME: begin
                ack         = 1'b1;
                fetch_valid = 1'b1;
            end
            ST_REJECT: begin
                ack      = 1'b1;
                prog_req = 1'b1;
            end
            default: ;
        endcase
    end

    // architected registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msr_q    <= msr_t'(MSR_RESET);
            srr0_q   <= '0;
            srr1_q   <= '0;
            srr2_q   <= '0;
            srr3_q   <= '0;
            esr_q    <= '0;
            dear_q   <= '0;
            tgt_q    <= '0;
            pfx_hi_q <= '0;
        end else begin
            if (pfx_we) pfx_hi_q <= pfx_wdata[AW-1:ALIGN_W];
            if (take_exc) begin
                if (req_crit) begin
                    srr2_q <= req_pc;
                    srr3_q <= msr_q;
                end else begin
                    srr0_q <= req_pc;
                    srr1_q <= msr_q;
                end
                if (syn_upd)  esr_q  <= req_syn;
                if (addr_upd) dear_q <= req_daddr;
                msr_q <= '{ce: (req_crit ? 1'b0 : msr_q.ce), ee: 1'b0,
                           priv: 1'b1, ir: 1'b0, dr: 1'b0};
                tgt_q <= vec_addr;
            end else if (ret_ok) begin
                msr_q <= ret_crit ? srr3_q : srr1_q;
                tgt_q <= ret_crit ? srr2_q : srr0_q;
            end else if ((state_q == ST_IDLE) && !ret_valid && msr_we) begin
                msr_q <= msr_t'(msr_wdata);
            end
        end
    end

    assign fetch_addr = tgt_q;
    assign msr        = msr_q;
    assign srr0       = srr0_q;
    assign srr1       = srr1_q;
    assign srr2       = srr2_q;
    assign srr3       = srr3_q;
    assign esr        = esr_q;
    assign dear       = dear_q;
endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk
    import trap_pkg::*;
#(
    parameter int AW    = 32,
    parameter int SYN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             idle,
    input logic             req_valid,
    input logic             req_crit,
    input logic [AW-1:0]    req_pc,
    input logic             ret_valid,
    input logic             syn_hit,
    input logic             addr_hit,
    input logic [MSR_W-1:0] msr,
    input logic [AW-1:0]    srr0,
    input logic [MSR_W-1:0] srr1,
    input logic [AW-1:0]    srr2,
    input logic [MSR_W-1:0] srr3,
    input logic [SYN_W-1:0] esr,
    input logic [AW-1:0]    dear,
    input logic             ack,
    input logic             fetch_valid,
    input logic             prog_req
);
    a_r1_crit_save: assert property (@(posedge clk) disable iff (!rst_n)
        idle && req_valid && req_crit |=>
            srr3 == $past(msr) && srr2 == $past(req_pc) && $stable(srr0) && $stable(srr1));

    a_r2_ncrit_save: assert property (@(posedge clk) disable iff (!rst_n)
        idle && req_valid && !req_crit |=>
            srr1 == $past(msr) && srr0 == $past(req_pc) && $stable(srr2) && $stable(srr3));

    a_r3_esr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        idle && req_valid && !syn_hit |=> $stable(esr));

    a_r4_dear_hold: assert property (@(posedge clk) disable iff (!rst_n)
        idle && req_valid && !addr_hit |=> $stable(dear));

    a_r5_real_mode: assert property (@(posedge clk) disable iff (!rst_n)
        idle && req_valid |=> msr[2] && !msr[1] && !msr[0]);

    a_r6_crit_masks: assert property (@(posedge clk) disable iff (!rst_n)
        idle && req_valid && req_crit |=> !msr[4] && !msr[3]);

    a_r8_no_early_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        idle && req_valid |-> !fetch_valid && !ack);

    a_r8_fetch_next: assert property (@(posedge clk) disable iff (!rst_n)
        idle && req_valid |=> fetch_valid && ack);

    a_r10_user_ret: assert property (@(posedge clk) disable iff (!rst_n)
        idle && !req_valid && ret_valid && !msr[2] |=>
            prog_req && !fetch_valid && $stable(msr));
endmodule

bind trap_seq trap_seq_chk #(.AW(AW), .SYN_W(SYN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle        (state_q == trap_pkg::ST_IDLE),
    .req_valid   (req_valid),
    .req_crit    (req_crit),
    .req_pc      (req_pc),
    .ret_valid   (ret_valid),
    .syn_hit     (syn_upd),
    .addr_hit    (addr_upd),
    .msr         (msr),
    .srr0        (srr0),
    .srr1        (srr1),
    .srr2        (srr2),
    .srr3        (srr3),
    .esr         (esr),
    .dear        (dear),
    .ack         (ack),
    .fetch_valid (fetch_valid),
    .prog_req    (prog_req)
);

// File: tb/trap_seq_bench.sv
`timescale 1ns/1ps
module trap_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_type = '0;
    logic        req_crit = 1'b0;
    logic [31:0] req_pc = '0;
    logic [31:0] req_daddr = '0;
    logic [7:0]  req_syn = '0;
    logic        ret_valid = 1'b0;
    logic        ret_crit = 1'b0;
    logic        msr_we = 1'b0;
    logic [4:0]  msr_wdata = '0;
    logic        pfx_we = 1'b0;
    logic [31:0] pfx_wdata = '0;
    logic        ack, fetch_valid, prog_req;
    logic [31:0] fetch_addr, srr0, srr2, dear;
    logic [4:0]  msr, srr1, srr3;
    logic [7:0]  esr;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    trap_seq u_trap_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_type(req_type), .req_crit(req_crit),
        .req_pc(req_pc), .req_daddr(req_daddr), .req_syn(req_syn),
        .ret_valid(ret_valid), .ret_crit(ret_crit),
        .msr_we(msr_we), .msr_wdata(msr_wdata),
        .pfx_we(pfx_we), .pfx_wdata(pfx_wdata),
        .ack(ack), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .prog_req(prog_req), .msr(msr),
        .srr0(srr0), .srr1(srr1), .srr2(srr2), .srr3(srr3),
        .esr(esr), .dear(dear)
    );

    task automatic chk(string rid, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", rid, what, act, exp);
        end
    endtask

    task automatic wr_msr(logic [4:0] v);
        @(negedge clk); msr_we = 1'b1; msr_wdata = v;
        @(negedge clk); msr_we = 1'b0;
    endtask

    task automatic wr_pfx(logic [31:0] v);
        @(negedge clk); pfx_we = 1'b1; pfx_wdata = v;
        @(negedge clk); pfx_we = 1'b0;
    endtask

    // drive a request, withdraw it one cycle later; results are then due
    task automatic do_entry(logic [3:0] t, logic c, logic [31:0] pc,
                            logic [31:0] da, logic [7:0] sy);
        @(negedge clk);
        req_valid = 1'b1; req_type = t; req_crit = c;
        req_pc = pc; req_daddr = da; req_syn = sy;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_ret(logic c);
        @(negedge clk); ret_valid = 1'b1; ret_crit = c;
        @(negedge clk); ret_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R8", "reset fetch_valid", 32'(fetch_valid), 32'h0);
        chk("R8", "reset ack", 32'(ack), 32'h0);
        chk("R10", "reset prog_req", 32'(prog_req), 32'h0);
        chk("R5", "reset msr", 32'(msr), 32'h04);
        chk("R3", "reset esr", 32'(esr), 32'h0);
        chk("R4", "reset dear", dear, 32'h0);
    endtask

    task automatic t_noncrit_entry();
        wr_pfx(32'hABCD_1234);
        wr_msr(5'h1C);
        do_entry(4'd4, 1'b0, 32'h0000_1000, 32'hDEAD_0000, 8'h5A);
        chk("R2", "srr0", srr0, 32'h1000);
        chk("R2", "srr1", 32'(srr1), 32'h1C);
        chk("R1", "srr2 untouched", srr2, 32'h0);
        chk("R6", "msr noncrit", 32'(msr), 32'h14);
        chk("R3", "esr kept type4", 32'(esr), 32'h0);
        chk("R4", "dear kept type4", dear, 32'h0);
        chk("R7", "vector type4", fetch_addr, 32'hABCD_0500);
        chk("R8", "fetch_valid next cycle", 32'(fetch_valid), 32'h1);
        chk("R8", "ack next cycle", 32'(ack), 32'h1);
        @(negedge clk);
        chk("R8", "fetch_valid one cycle", 32'(fetch_valid), 32'h0);
        chk("R8", "ack one cycle", 32'(ack), 32'h0);
    endtask

    task automatic t_crit_entry();
        wr_msr(5'h1F);
        do_entry(4'd1, 1'b1, 32'h0000_2000, 32'h0000_3000, 8'hC3);
        chk("R1", "srr3", 32'(srr3), 32'h1F);
        chk("R1", "srr2", srr2, 32'h2000);
        chk("R2", "srr0 untouched", srr0, 32'h1000);
        chk("R5", "msr real mode", 32'(msr), 32'h04);
        chk("R3", "esr type1", 32'(esr), 32'hC3);
        chk("R4", "dear kept type1", dear, 32'h0);
        chk("R7", "vector type1", fetch_addr, 32'hABCD_0200);
    endtask

    task automatic t_type_sweep();
        logic [7:0]  e_esr  = 8'hC3;
        logic [31:0] e_dear = 32'h0;
        for (int t = 0; t < 16; t++) begin
            logic [7:0]  sy = 8'h40 + 8'(t);
            logic [31:0] da = 32'h8000_0000 + 32'(t * 16);
            if (t == 1 || t == 2 || t == 3 || t == 6 || t == 11) e_esr = sy;
            if (t == 2 || t == 5 || t == 11) e_dear = da;
            do_entry(4'(t), 1'b0, 32'h100 + 32'(t), da, sy);
            chk("R3", $sformatf("esr type%0d", t), 32'(esr), 32'(e_esr));
            chk("R4", $sformatf("dear type%0d", t), dear, e_dear);
            chk("R7", $sformatf("vector type%0d", t), fetch_addr,
                {16'hABCD, 16'((t + 1) * 256)});
        end
    endtask

    task automatic t_returns();
        wr_msr(5'h1C);
        do_entry(4'd7, 1'b0, 32'h0000_4444, 32'h0, 8'h0);
        do_entry(4'd0, 1'b1, 32'h0000_5555, 32'h0, 8'h0);
        chk("R1", "srr3 nested", 32'(srr3), 32'h14);
        do_ret(1'b1);
        chk("R9", "rfci fetch", fetch_addr, 32'h5555);
        chk("R9", "rfci msr", 32'(msr), 32'h14);
        chk("R9", "rfci fetch_valid", 32'(fetch_valid), 32'h1);
        do_ret(1'b0);
        chk("R9", "rfi fetch", fetch_addr, 32'h4444);
        chk("R9", "rfi msr", 32'(msr), 32'h1C);
        chk("R9", "rfi ack", 32'(ack), 32'h1);
        chk("R10", "rfi no prog_req", 32'(prog_req), 32'h0);
    endtask

    task automatic t_user_ret();
        wr_msr(5'h18);
        do_ret(1'b0);
        chk("R10", "prog_req", 32'(prog_req), 32'h1);
        chk("R10", "no fetch", 32'(fetch_valid), 32'h0);
        chk("R10", "ack", 32'(ack), 32'h1);
        chk("R10", "msr kept", 32'(msr), 32'h18);
        @(negedge clk);
        chk("R10", "prog_req one cycle", 32'(prog_req), 32'h0);
    endtask

    task automatic t_priority();
        wr_msr(5'h1C);
        @(negedge clk);
        req_valid = 1'b1; req_type = 4'd9; req_crit = 1'b0; req_pc = 32'h6000;
        ret_valid = 1'b1; ret_crit = 1'b0;
        msr_we = 1'b1; msr_wdata = 5'h03;
        @(negedge clk);
        req_valid = 1'b0; ret_valid = 1'b0; msr_we = 1'b0;
        chk("R11", "entry wins vector", fetch_addr, 32'hABCD_0A00);
        chk("R11", "entry wins srr0", srr0, 32'h6000);
        chk("R11", "msr write ignored", 32'(msr), 32'h14);
        chk("R11", "no prog_req", 32'(prog_req), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_noncrit_entry();
        t_crit_entry();
        t_type_sweep();
        t_returns();
        t_user_ret();
        t_priority();
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule